// File: doc/BRIEF.md
# Pin Interrupt Edge/Level Controller

This block turns a set of already synchronized input lines into per-channel interrupt requests. Each channel runs in one of two modes. In edge mode it latches rising and/or falling transitions into sticky capture bits. In level mode it asserts its request for as long as the input sits at a chosen level. A single pair of enable bits per channel is reused: in edge mode the two bits gate rising and falling capture, and in level mode one bit gates the channel and the other picks the active level.

Software drives the block through a simple word-addressed register port. The access is valid when `bus_sel` is high, with `bus_wr` picking write or read, and read data is returned combinationally in the same cycle. Both enable registers have write-only aliases that set or clear individual bits, so channels can be changed without a read-modify-write.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The sampled copy of `pin_in` also resets low.
- R2: The mode word at offset 0x00 holds bit i = 0 for edge mode and 1 for level mode on channel i. It reads back bits NCH-1:0, with the upper read bits zero.
- R3: The rise/level enable word (0x04) and the fall/polarity word (0x10) are fully writable and read back what was written.
- R4: For the first enable, offset 0x08 sets and 0x0C clears; for the second, 0x14 sets and 0x18 clears. Each 1 bit acts on the matching enable bit and each 0 bit leaves it unchanged.
- R5: A channel in edge mode samples `pin_in` every cycle. A low-to-high change with the first enable set sets its bit in the rise capture word (0x1C). A high-to-low change with the second enable set sets its bit in the fall capture word (0x20). Both become visible after the clock edge at which the new input value is first seen. Without the matching enable, nothing is recorded.
- R6: Capture bits stay set whatever the input does afterwards. Writing 1 to a bit of 0x1C or 0x20 clears that bit. Writing 1 to a status bit (0x24) of an edge channel clears both of its capture bits. A new edge in the same cycle as a clear wins.
- R7: For an edge channel, the status bit at 0x24 and `irq` equal the OR of its two capture bits. For a level channel, they equal first-enable AND (sampled input == second enable), where a second-enable value of 1 means active high. Level channels record no captures.
- R8: Writing 1 to the status bit of a level channel toggles its second enable, which inverts its active level.
- R9: Reads of the four alias offsets, of unmapped offsets (including unaligned ones), and any cycle without a read return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle |
| pin_in | input | NCH | Synchronized channel inputs |
| irq | output | NCH | Per-channel interrupt request |

## Verification
A corrupted capture bit or enable shows up on `irq` and on the status read one clock after it happens, because the request is a plain combination of registered state. A mode bit stuck wrong turns a held level into a single latched pulse, or the reverse, so the check after each input change tells the two apart. A lost set/clear alias bit, or a clear that beats a simultaneous edge, is seen on the very next read of the affected word.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] irq
);
  localparam logic [AW-1:0] A_MODE = AW'('h00);
  localparam logic [AW-1:0] A_ENR  = AW'('h04);
  localparam logic [AW-1:0] A_SETR = AW'('h08);
  localparam logic [AW-1:0] A_CLRR = AW'('h0C);
  localparam logic [AW-1:0] A_ENF  = AW'('h10);
  localparam logic [AW-1:0] A_SETF = AW'('h14);
  localparam logic [AW-1:0] A_CLRF = AW'('h18);
  localparam logic [AW-1:0] A_RDET = AW'('h1C);
  localparam logic [AW-1:0] A_FDET = AW'('h20);
  localparam logic [AW-1:0] A_STAT = AW'('h24);

  logic [NCH-1:0] mode_q, enr_q, enf_q, rdet_q, fdet_q, samp_q;
  logic [NCH-1:0] wbits, rise_ev, fall_ev, lvl_st, status, clr_det;

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;
  assign wbits = bus_wdata[NCH-1:0];

  wire hit_mode = wr_en && bus_addr == A_MODE;
  wire hit_enr  = wr_en && bus_addr == A_ENR;
  wire hit_setr = wr_en && bus_addr == A_SETR;
  wire hit_clrr = wr_en && bus_addr == A_CLRR;
  wire hit_enf  = wr_en && bus_addr == A_ENF;
  wire hit_setf = wr_en && bus_addr == A_SETF;
  wire hit_clrf = wr_en && bus_addr == A_CLRF;
  wire hit_rdet = wr_en && bus_addr == A_RDET;
  wire hit_fdet = wr_en && bus_addr == A_FDET;
  wire hit_stat = wr_en && bus_addr == A_STAT;

  assign rise_ev = pin_in & ~samp_q & enr_q & ~mode_q;
  assign fall_ev = ~pin_in & samp_q & enf_q & ~mode_q;
  assign lvl_st  = mode_q & enr_q & ~(samp_q ^ enf_q);
  assign status  = (~mode_q & (rdet_q | fdet_q)) | lvl_st;
  assign irq     = status;
  assign clr_det = hit_stat ? (wbits & ~mode_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      enr_q  <= '0;
      enf_q  <= '0;
      rdet_q <= '0;
      fdet_q <= '0;
      samp_q <= '0;
    end else begin
      samp_q <= pin_in;
      if (hit_mode) mode_q <= wbits;
      if (hit_enr)       enr_q <= wbits;
      else if (hit_setr) enr_q <= enr_q | wbits;
      else if (hit_clrr) enr_q <= enr_q & ~wbits;
      if (hit_enf)       enf_q <= wbits;
      else if (hit_setf) enf_q <= enf_q | wbits;
      else if (hit_clrf) enf_q <= enf_q & ~wbits;
      else if (hit_stat) enf_q <= enf_q ^ (wbits & mode_q);
      rdet_q <= (rdet_q & ~(clr_det | (hit_rdet ? wbits : '0))) | rise_ev;
      fdet_q <= (fdet_q & ~(clr_det | (hit_fdet ? wbits : '0))) | fall_ev;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_MODE:  bus_rdata[NCH-1:0] = mode_q;
        A_ENR:   bus_rdata[NCH-1:0] = enr_q;
        A_ENF:   bus_rdata[NCH-1:0] = enf_q;
        A_RDET:  bus_rdata[NCH-1:0] = rdet_q;
        A_FDET:  bus_rdata[NCH-1:0] = fdet_q;
        A_STAT:  bus_rdata[NCH-1:0] = status;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] pin_in,
  input logic [NCH-1:0] samp_q,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] enr_q,
  input logic [NCH-1:0] enf_q,
  input logic [NCH-1:0] rdet_q
);
  wire wr_en = bus_sel & bus_wr;
  wire mapped = bus_addr <= AW'('h24) && bus_addr[1:0] == 2'b00;

  p_alias_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == AW'('h08) || bus_addr == AW'('h18))) |-> bus_rdata == '0);

  p_set_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'('h08)) |=> (enr_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]));

  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == AW'('h0C)) |=> (enr_q & $past(bus_wdata[NCH-1:0])) == '0);

  p_edge_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rdet_q & ~$past(rdet_q) &
              ~($past(enr_q) & $past(pin_in) & ~$past(samp_q) & ~$past(mode_q))) == '0);

  p_capture_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (bus_addr == AW'('h1C) || bus_addr == AW'('h24))) |=> (rdet_q & $past(rdet_q)) == $past(rdet_q));

  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> ($stable(mode_q) && $stable(enr_q) && $stable(enf_q)));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .samp_q(samp_q), .mode_q(mode_q), .enr_q(enr_q),
  .enf_q(enf_q), .rdet_q(rdet_q)
);

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pin_irq_ctrl #(.NCH(8), .AW(6), .DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_pin(input logic [5:0] a, input logic [31:0] d, input logic [7:0] p);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pin_in = p;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_pin(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
  endtask

  task automatic chk_irq(input logic [7:0] e, input string tag);
    @(negedge clk);
    #5;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual %h expected %h", tag, irq, e);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_sel && !bus_wr && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk_irq(8'h00, "R1");
    for (int a = 0; a <= 'h24; a += 4) rd(6'(a), 32'h0, "R1");
    // R2 mode
    wr(6'h00, 32'hABCD_12F0);
    rd(6'h00, 32'h0000_00F0, "R2");
    // R3 R4 enables and aliases
    wr(6'h04, 32'h05);
    rd(6'h04, 32'h05, "R3");
    wr(6'h08, 32'h0A);
    rd(6'h04, 32'h0F, "R4");
    wr(6'h0C, 32'h03);
    rd(6'h04, 32'h0C, "R4");
    wr(6'h08, 32'h00);
    rd(6'h04, 32'h0C, "R4");
    rd(6'h08, 32'h0, "R9");
    wr(6'h10, 32'h09);
    wr(6'h14, 32'h20);
    wr(6'h18, 32'h01);
    rd(6'h10, 32'h28, "R4");
    // R5 R7 edge capture
    set_pin(8'h0F);
    chk_irq(8'h0C, "R5");
    rd(6'h1C, 32'h0C, "R5");
    rd(6'h20, 32'h00, "R5");
    rd(6'h24, 32'h0C, "R7");
    set_pin(8'h00);
    chk_irq(8'h0C, "R5");
    rd(6'h20, 32'h08, "R5");
    rd(6'h1C, 32'h0C, "R6");
    // R6 clears
    wr(6'h1C, 32'h04);
    rd(6'h1C, 32'h08, "R6");
    chk_irq(8'h08, "R7");
    wr(6'h24, 32'h08);
    chk_irq(8'h00, "R6");
    rd(6'h20, 32'h00, "R6");
    // R5 no enable
    set_pin(8'h02);
    chk_irq(8'h00, "R5");
    rd(6'h1C, 32'h00, "R5");
    set_pin(8'h00);
    // R6 edge beats clear
    wr_pin(6'h1C, 32'h04, 8'h04);
    rd(6'h1C, 32'h04, "R6");
    wr(6'h1C, 32'h04);
    rd(6'h1C, 32'h00, "R6");
    set_pin(8'h00);
    // R7 R8 level mode on channel 5
    wr(6'h08, 32'h20);
    chk_irq(8'h00, "R7");
    set_pin(8'h20);
    chk_irq(8'h20, "R7");
    rd(6'h1C, 32'h00, "R7");
    wr(6'h24, 32'h20);
    chk_irq(8'h00, "R8");
    rd(6'h10, 32'h08, "R8");
    set_pin(8'h00);
    chk_irq(8'h20, "R8");
    // R9 unmapped
    wr(6'h28, 32'hFF);
    wr(6'h02, 32'hFF);
    rd(6'h00, 32'hF0, "R9");
    rd(6'h04, 32'h2C, "R9");
    rd(6'h28, 32'h00, "R9");
    rd(6'h14, 32'h00, "R9");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule